// File: doc/BRIEF.md
# Integrate-and-Fire Membrane Update Pipeline

This block advances the membrane voltage of one population of integrate-and-fire neurons by one forward-Euler time step. A sequencer outside the block walks the per-neuron state RAM and presents one neuron per clock. Each presented word carries the neuron's index, membrane voltage, refractory count, and excitatory and inhibitory conductances. The block returns the updated voltage and refractory count for write-back two clocks later. For every neuron that crossed the threshold in this step, it also raises a spike strobe with that neuron's index.

The datapath works in signed fixed point. Driving forces are formed against two fixed reversal potentials, one per channel type, and saturated to the voltage width. They are scaled by unsigned fractional conductances to give the inward and outward currents. The current difference is scaled by a constant that folds in the membrane capacitance and the step size, and is then added to the voltage. A neuron that is still counting down its refractory hold skips integration: it is pinned at the reset voltage and its counter is decremented. Reset voltage, threshold, hold length, reversal potentials and the scale factor are all elaboration parameters.

Top module: `memb_update`

## Requirements
- R1: A word presented with `in_valid` high produces `out_valid` high exactly two clocks later. A word is accepted on every clock, so back-to-back words are all processed.
- R2: Results leave in the order in which words were presented, and each result carries the index of its own word on `out_idx`.
- R3: The excitatory driving force is E_EXC minus the voltage, and the inhibitory driving force is the voltage minus E_INH. Both are saturated to the signed VW-bit range.
- R4: Each channel current is floor(g × drive / 2^GW), where the conductance g is an unsigned fraction of GW bits.
- R5: With a refractory count of zero, the integrated voltage is the input voltage plus floor((Iexc − Iinh) × LAMBDA_MUL / 2^LAMBDA_SHIFT), saturated to signed VW bits.
- R6: With a refractory count of zero and an integrated voltage greater than or equal to VTHRESH, the result is a spike. `spike_valid` is high with `spike_idx` equal to the word's index, `out_vm` is VRESET and `out_refr` is TREFRACT.
- R7: With a refractory count of zero and an integrated voltage below VTHRESH, `out_vm` is the integrated voltage, `out_refr` is zero and no spike is raised.
- R8: With a nonzero refractory count, `out_vm` is VRESET, `out_refr` is the count minus one and no spike is raised. The conductances and the input voltage have no effect on the result.
- R9: While `rst_n` is low and in the first two clocks after it is released, `out_valid` and `spike_valid` are low.
- R10: A clock with `in_valid` low produces no result and no spike two clocks later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input word present this clock |
| in_idx | input | IDXW | Neuron index |
| in_vm | input | VW | Membrane voltage, signed |
| in_refr | input | CW | Remaining refractory steps |
| in_gexc | input | GW | Excitatory conductance, unsigned fraction |
| in_ginh | input | GW | Inhibitory conductance, unsigned fraction |
| out_valid | output | 1 | Write-back word present |
| out_idx | output | IDXW | Neuron index of the write-back word |
| out_vm | output | VW | Updated membrane voltage, signed |
| out_refr | output | CW | Updated refractory count |
| spike_valid | output | 1 | Spike strobe |
| spike_idx | output | IDXW | Index of the spiking neuron |

## Verification
A neuron can emit a spike from the output stage in the same cycle that the next neuron enters the pipeline in refractory hold. The threshold test and the hold bypass also meet inside a single word, when a neuron whose count is nonzero already sits above threshold with large conductances. Back-to-back streams mix refractory and non-refractory words with voltages placed exactly at the threshold and one step below it. Every write-back word, strobe and index is compared against a bench model of the fixed-point arithmetic, taken two clocks after the word was presented.

// File: rtl/memb_pkg.sv
package memb_pkg;
    localparam int ACC_W = 48;
    typedef logic signed [ACC_W-1:0] acc_t;

    // clamp a wide signed value into the range of a w-bit signed number
    function automatic acc_t clamp(input acc_t x, input int unsigned w);
        acc_t hi;
        acc_t lo;
        hi = (acc_t'(1) <<< (w - 1)) - acc_t'(1);
        lo = -hi - acc_t'(1);
        if (x > hi) return hi;
        if (x < lo) return lo;
        return x;
    endfunction
endpackage

// File: rtl/memb_drive.sv
module memb_drive
    import memb_pkg::*;
#(
    parameter int VW    = 16,
    parameter bit INHIB = 1'b0,
    parameter int EREV  = 0
) (
    input  logic signed [VW-1:0] vm,
    output logic signed [VW-1:0] drv
);
    acc_t diff;
    acc_t sat;
    always_comb begin
        diff = INHIB ? (acc_t'(vm) - acc_t'(EREV)) : (acc_t'(EREV) - acc_t'(vm));
        sat  = clamp(diff, VW);
        drv  = sat[VW-1:0];
    end
endmodule

// File: rtl/memb_integrate.sv
module memb_integrate
    import memb_pkg::*;
#(
    parameter int VW           = 16,
    parameter int GW           = 16,
    parameter int LAMBDA_MUL   = 16,
    parameter int LAMBDA_SHIFT = 8
) (
    input  logic signed [VW-1:0] vm,
    input  logic        [GW-1:0] g_exc,
    input  logic        [GW-1:0] g_inh,
    input  logic signed [VW-1:0] d_exc,
    input  logic signed [VW-1:0] d_inh,
    output logic signed [VW-1:0] v_next
);
    acc_t i_exc, i_inh, net, dv, sum, sat;
    always_comb begin
        i_exc  = (acc_t'({1'b0, g_exc}) * acc_t'(d_exc)) >>> GW;
        i_inh  = (acc_t'({1'b0, g_inh}) * acc_t'(d_inh)) >>> GW;
        net    = i_exc - i_inh;
        dv     = (net * acc_t'(LAMBDA_MUL)) >>> LAMBDA_SHIFT;
        sum    = acc_t'(vm) + dv;
        sat    = clamp(sum, VW);
        v_next = sat[VW-1:0];
    end
endmodule

// File: rtl/memb_fire.sv
module memb_fire
    import memb_pkg::*;
#(
    parameter int VW       = 16,
    parameter int CW       = 4,
    parameter int VRESET   = -15360,
    parameter int VTHRESH  = -12800,
    parameter int TREFRACT = 3
) (
    input  logic signed [VW-1:0] v_next,
    input  logic        [CW-1:0] refr,
    output logic signed [VW-1:0] v_out,
    output logic        [CW-1:0] refr_out,
    output logic                 fire
);
    localparam logic [VW-1:0] VRST_V = VRESET[VW-1:0];
    localparam logic [CW-1:0] TREF_V = TREFRACT[CW-1:0];

    always_comb begin
        fire     = 1'b0;
        v_out    = v_next;
        refr_out = '0;
        if (refr != '0) begin
            v_out    = VRST_V;
            refr_out = refr - CW'(1);
        end else if (acc_t'(v_next) >= acc_t'(VTHRESH)) begin
            fire     = 1'b1;
            v_out    = VRST_V;
            refr_out = TREF_V;
        end
    end
endmodule

// File: rtl/memb_update.sv
module memb_update
    import memb_pkg::*;
#(
    parameter int VW           = 16,
    parameter int GW           = 16,
    parameter int CW           = 4,
    parameter int IDXW         = 7,
    parameter int E_EXC        = 0,
    parameter int E_INH        = -20480,
    parameter int LAMBDA_MUL   = 16,
    parameter int LAMBDA_SHIFT = 8,
    parameter int VRESET       = -15360,
    parameter int VTHRESH      = -12800,
    parameter int TREFRACT     = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [IDXW-1:0]        in_idx,
    input  logic signed [VW-1:0]   in_vm,
    input  logic [CW-1:0]          in_refr,
    input  logic [GW-1:0]          in_gexc,
    input  logic [GW-1:0]          in_ginh,
    output logic                   out_valid,
    output logic [IDXW-1:0]        out_idx,
    output logic signed [VW-1:0]   out_vm,
    output logic [CW-1:0]          out_refr,
    output logic                   spike_valid,
    output logic [IDXW-1:0]        spike_idx
);
    localparam int NCH = 2;

    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] idx;
        logic [VW-1:0]   vm;
        logic [CW-1:0]   refr;
        logic [GW-1:0]   gexc;
        logic [GW-1:0]   ginh;
        logic [VW-1:0]   dexc;
        logic [VW-1:0]   dinh;
    } drive_stage_t;

    typedef struct packed {
        logic            valid;
        logic [IDXW-1:0] idx;
        logic [VW-1:0]   vm;
        logic [CW-1:0]   refr;
        logic            spike;
    } wb_stage_t;

    typedef struct packed {
        drive_stage_t s1;
        wb_stage_t    s2;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic signed [VW-1:0] drv [NCH];
    logic signed [VW-1:0] v_next, v_out;
    logic [CW-1:0]        refr_next;
    logic                 fire;

    // channel 0 excitatory, channel 1 inhibitory
    for (genvar c = 0; c < NCH; c++) begin : g_chan
        memb_drive #(
            .VW   (VW),
            .INHIB(c == 1),
            .EREV ((c == 1) ? E_INH : E_EXC)
        ) u_drive (
            .vm (in_vm),
            .drv(drv[c])
        );
    end

    memb_integrate #(
        .VW          (VW),
        .GW          (GW),
        .LAMBDA_MUL  (LAMBDA_MUL),
        .LAMBDA_SHIFT(LAMBDA_SHIFT)
    ) u_integ (
        .vm    ($signed(pipe_q.s1.vm)),
        .g_exc (pipe_q.s1.gexc),
        .g_inh (pipe_q.s1.ginh),
        .d_exc ($signed(pipe_q.s1.dexc)),
        .d_inh ($signed(pipe_q.s1.dinh)),
        .v_next(v_next)
    );

    memb_fire #(
        .VW      (VW),
        .CW      (CW),
        .VRESET  (VRESET),
        .VTHRESH (VTHRESH),
        .TREFRACT(TREFRACT)
    ) u_fire (
        .v_next  (v_next),
        .refr    (pipe_q.s1.refr),
        .v_out   (v_out),
        .refr_out(refr_next),
        .fire    (fire)
    );

    always_comb begin
        pipe_d          = pipe_q;
        pipe_d.s1.valid = in_valid;
        pipe_d.s1.idx   = in_idx;
        pipe_d.s1.vm    = in_vm;
        pipe_d.s1.refr  = in_refr;
        pipe_d.s1.gexc  = in_gexc;
        pipe_d.s1.ginh  = in_ginh;
        pipe_d.s1.dexc  = drv[0];
        pipe_d.s1.dinh  = drv[1];
        pipe_d.s2.valid = pipe_q.s1.valid;
        pipe_d.s2.idx   = pipe_q.s1.idx;
        pipe_d.s2.vm    = v_out;
        pipe_d.s2.refr  = refr_next;
        pipe_d.s2.spike = pipe_q.s1.valid & fire;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pipe_q <= '0;
        else        pipe_q <= pipe_d;
    end

    assign out_valid   = pipe_q.s2.valid;
    assign out_idx     = pipe_q.s2.idx;
    assign out_vm      = pipe_q.s2.vm;
    assign out_refr    = pipe_q.s2.refr;
    assign spike_valid = pipe_q.s2.spike;
    assign spike_idx   = pipe_q.s2.idx;
endmodule

// File: rtl/memb_update_chk.sv
module memb_update_chk #(
    parameter int VW       = 16,
    parameter int CW       = 4,
    parameter int IDXW     = 7,
    parameter int VRESET   = -15360,
    parameter int VTHRESH  = -12800,
    parameter int TREFRACT = 3
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic [IDXW-1:0]      in_idx,
    input logic [CW-1:0]        in_refr,
    input logic                 out_valid,
    input logic [IDXW-1:0]      out_idx,
    input logic signed [VW-1:0] out_vm,
    input logic [CW-1:0]        out_refr,
    input logic                 spike_valid,
    input logic [IDXW-1:0]      spike_idx
);
    localparam logic signed [VW-1:0] VRST_V = VRESET[VW-1:0];
    localparam logic [CW-1:0]        TREF_V = TREFRACT[CW-1:0];

    a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |-> ##2 out_valid);

    a_r2_index: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_idx == $past(in_idx, 2));

    a_r6_fire_load: assert property (@(posedge clk) disable iff (!rst_n)
        spike_valid |-> (out_valid && out_vm == VRST_V && out_refr == TREF_V && spike_idx == out_idx));

    a_r7_below_threshold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !spike_valid && $past(in_refr, 2) == '0) |-> ($signed(out_vm) < VTHRESH && out_refr == '0));

    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_valid, 2) && $past(in_refr, 2) != '0) |->
        (!spike_valid && out_vm == VRST_V && out_refr == $past(in_refr, 2) - CW'(1)));

    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid, 2) |-> (!out_valid && !spike_valid));
endmodule

bind memb_update memb_update_chk #(
    .VW(VW), .CW(CW), .IDXW(IDXW), .VRESET(VRESET), .VTHRESH(VTHRESH), .TREFRACT(TREFRACT)
) u_chk (.*);

// File: tb/tb_memb_update.sv
`timescale 1ns/1ps
module tb_memb_update;
    localparam int VW = 16, GW = 16, CW = 4, IDXW = 7;
    localparam int E_EXC = 0, E_INH = -20480;
    localparam int LMUL = 16, LSH = 8;
    localparam int VRESET = -15360, VTHRESH = -12800, TREFRACT = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0;
    logic [IDXW-1:0] in_idx = '0;
    logic signed [VW-1:0] in_vm = '0;
    logic [CW-1:0] in_refr = '0;
    logic [GW-1:0] in_gexc = '0, in_ginh = '0;
    logic out_valid, spike_valid;
    logic [IDXW-1:0] out_idx, spike_idx;
    logic signed [VW-1:0] out_vm;
    logic [CW-1:0] out_refr;

    always #2.5 clk = ~clk;

    memb_update #(
        .VW(VW), .GW(GW), .CW(CW), .IDXW(IDXW), .E_EXC(E_EXC), .E_INH(E_INH),
        .LAMBDA_MUL(LMUL), .LAMBDA_SHIFT(LSH), .VRESET(VRESET), .VTHRESH(VTHRESH),
        .TREFRACT(TREFRACT)
    ) dut (.*);

    typedef struct {
        bit    v;
        int    idx;
        int    vm;
        int    refr;
        bit    spk;
        string tag;
    } exp_t;

    exp_t pipe0, pipe1;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    function automatic longint clampv(longint x);
        if (x > 32767) return 32767;
        if (x < -32768) return -32768;
        return x;
    endfunction

    function automatic exp_t model(bit v, int idx, int vm, int refr, int ge, int gi, string tag);
        exp_t e;
        longint de, di, ie, ii, vn;
        e.v = v; e.idx = idx; e.tag = tag; e.spk = 1'b0;
        de = clampv(longint'(E_EXC) - vm);                    // R3
        di = clampv(longint'(vm) - E_INH);
        ie = (longint'(ge) * de) >>> GW;                      // R4
        ii = (longint'(gi) * di) >>> GW;
        vn = clampv(vm + (((ie - ii) * LMUL) >>> LSH));       // R5
        if (refr != 0) begin                                  // R8
            e.vm = VRESET; e.refr = refr - 1;
        end else if (vn >= VTHRESH) begin                     // R6
            e.vm = VRESET; e.refr = TREFRACT; e.spk = v;
        end else begin                                        // R7
            e.vm = int'(vn); e.refr = 0;
        end
        return e;
    endfunction

    task automatic chk(bit ok, string req, int act, int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    task automatic step(bit v, int idx, int vm, int refr, int ge, int gi, string tag);
        @(negedge clk);
        if (!done) begin
            chk(out_valid == pipe1.v, "R1/R10 out_valid", int'(out_valid), int'(pipe1.v));
            chk(spike_valid == pipe1.spk, {pipe1.tag, " spike"}, int'(spike_valid), int'(pipe1.spk));
            if (pipe1.v) begin
                chk(int'(out_idx) == pipe1.idx, "R2 index", int'(out_idx), pipe1.idx);
                chk(int'(out_vm) == pipe1.vm, {pipe1.tag, " voltage"}, int'(out_vm), pipe1.vm);
                chk(int'(out_refr) == pipe1.refr, {pipe1.tag, " refractory"}, int'(out_refr), pipe1.refr);
                if (pipe1.spk)
                    chk(int'(spike_idx) == pipe1.idx, "R6 spike index", int'(spike_idx), pipe1.idx);
            end
        end
        pipe1 = pipe0;
        pipe0 = model(v, idx, vm, refr, ge, gi, tag);
        in_valid = v;
        in_idx   = IDXW'(idx);
        in_vm    = VW'(vm);
        in_refr  = CW'(refr);
        in_gexc  = GW'(ge);
        in_ginh  = GW'(gi);
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            done = 1'b1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        int seed;
        seed = 32'h5EED;
        void'($urandom(seed));
        pipe0 = model(0, 0, 0, 0, 0, 0, "R10");
        pipe1 = pipe0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R9 reset out_valid", int'(out_valid), 0);
        chk(spike_valid == 1'b0, "R9 reset spike_valid", int'(spike_valid), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R9 after release", int'(out_valid), 0);

        // directed corners
        step(1, 1, -14000, 0, 0, 0, "R5 zero conductance");
        step(1, 2, VTHRESH, 0, 0, 0, "R6 exact threshold");
        step(1, 3, VTHRESH - 1, 0, 0, 0, "R7 one below threshold");
        step(1, 4, -32768, 0, 65535, 0, "R3 excitatory saturation");
        step(1, 5, 32767, 0, 0, 65535, "R3 inhibitory saturation");
        step(1, 6, -20480, 0, 32768, 65535, "R4 zero inhibitory drive");
        step(1, 7, 20000, 2, 65535, 0, "R8 hold ignores inputs");
        step(1, 8, -13000, 1, 65535, 0, "R8 last hold step");
        step(0, 9, 20000, 0, 65535, 0, "R10 idle word");
        step(1, 10, VTHRESH, 0, 0, 0, "R6 spike beside hold");
        step(1, 11, VTHRESH, 3, 65535, 65535, "R8 hold above threshold");
        step(1, 12, -16000, 0, 40000, 1000, "R5 excitatory push");

        // constrained random stream
        for (int n = 0; n < 4000; n++) begin
            int r, vm, refr;
            r    = int'($urandom_range(0, 9));
            refr = (r < 6) ? 0 : int'($urandom_range(1, TREFRACT));
            vm   = (r == 9) ? int'($urandom_range(0, 65535)) - 32768
                            : int'($urandom_range(0, 10000)) - 20000;
            step($urandom_range(0, 7) != 0, int'($urandom_range(0, 127)), vm, refr,
                 int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                 (refr != 0) ? "R8 random" : "R5/R6/R7 random");
        end
        step(0, 0, 0, 0, 0, 0, "R10 drain");
        step(0, 0, 0, 0, 0, 0, "R10 drain");
        step(0, 0, 0, 0, 0, 0, "R10 drain");

        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule